// File: doc/BRIEF.md
# Power-Managed Serial ADC Sampling Sequencer

This block runs a three-wire serial sampling converter from the host side. It drives the active-low chip select and the serial clock from the system clock, and it shifts in the 16-bit result frame on the converter's data line. Each result is presented as a word with a one-cycle valid pulse. The serial clock period is set by a programmable half-period divider. A sample period counter spaces the conversions.

The block signals to the converter through the length of each frame. A frame that ends early, after between 2 and 10 falling clock edges, puts the converter to sleep. A frame of 10 edges wakes it again, and that frame also acts as the acquisition window. A full 16-clock frame produces a result. After reset, one throw-away frame settles the converter into a known state: a full frame leaves it awake, and a short frame leaves it asleep.

The sleep-between-samples sequence runs only when it is enabled and the sample period is long enough for power-down to pay off. The sequence is wake, quiet gap, conversion, quiet gap, sleep entry, quiet gap. If the programmed period cannot hold this sequence, the block raises an overrun flag and issues plain conversion frames only. The configuration inputs are read continuously and are meant to be changed only while reset is held.

Top module: `sadc_pm_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `adc_cs_n` and `adc_sclk` are 1, and `sample_valid` and `overrun` are 0.
- R2: A frame holds `adc_cs_n` low for N serial clock periods. Each period is 2H system cycles, low for the first H and high for the next H, where H = `cfg_half_div`, or 1 when that input is 0. `adc_sclk` is 1 whenever `adc_cs_n` is 1.
- R3: Between any two frames, `adc_cs_n` stays high for at least QUIET_CLKS cycles. The gap after a conversion frame and the gap after a sleep-entry frame are exactly QUIET_CLKS cycles.
- R4: A conversion frame has N = 16. `adc_sdo` is sampled in the last system cycle of each high phase, so bit k is read after the k-th falling edge, most significant bit first. The 16-bit word appears on `sample_data` with `sample_valid` high for exactly the first cycle after the frame.
- R5: The first frame after reset is a dummy frame and produces no valid pulse. It has N = 16 when `cfg_dummy_sleep` = 0 and N = E when it is 1. It is followed by a QUIET_CLKS gap and one idle cycle before the first sample sequence.
- R6: In power-down mode, each conversion gap is followed by a sleep-entry frame with N = E, where E is `cfg_sleep_edges` clamped to the range 2 to 10.
- R7: While the converter is asleep, a sample sequence opens with a 10-period wake frame that produces no valid pulse. The gap after it is max(QUIET_CLKS, WAKE_CLKS − 20H), so at least WAKE_CLKS cycles pass from the wake frame's falling select to the conversion frame's falling select.
- R8: Power-down mode is in force only when `cfg_sleep_en` = 1, `cfg_period` ≥ PD_MIN_PERIOD and there is no overrun. Otherwise only conversion frames are issued, with a single wake frame first if the dummy frame left the converter asleep.
- R9: Consecutive sample sequences start exactly `cfg_period` cycles apart when the sequence fits in the period. Otherwise they are separated by exactly one idle cycle.
- R10: `overrun` is registered. It is 1 exactly when `cfg_sleep_en` = 1, `cfg_period` ≥ PD_MIN_PERIOD and `cfg_period` < 52H + Gw + 2EH + 2·QUIET_CLKS + 1, where Gw is the wake gap from R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_div | input | DIV_W | Serial clock half-period in system cycles (0 treated as 1) |
| cfg_period | input | PER_W | Sample period in system cycles |
| cfg_sleep_en | input | 1 | Enable power-down between samples |
| cfg_sleep_edges | input | 4 | Falling edges in a sleep-entry frame, clamped to 2..10 |
| cfg_dummy_sleep | input | 1 | Dummy frame after reset leaves converter asleep |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock, parked high |
| adc_sdo | input | 1 | Converter serial data |
| sample_data | output | 16 | Captured conversion word |
| sample_valid | output | 1 | One-cycle strobe for `sample_data` |
| overrun | output | 1 | Sample period too short for the sleep sequence |

## Verification
The bench builds the block with QUIET_CLKS = 3, WAKE_CLKS = 40 and PD_MIN_PERIOD = 300, so that every run stays short. With a wake time of 40 cycles, a half divider of 1 needs the wake gap stretched to 20 cycles, while a half divider of 3 does not. A threshold of 300 lets periods of 299 and 300 sit on either side of the power-down cut-off. Periods of 345 and 346 with a half divider of 6 fall exactly one cycle short of and exactly on the sequence length, and a period of 10 forces frames back to back.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_DUMMY,
        ST_GAPD,
        ST_IDLE,
        ST_WAKE,
        ST_GAPW,
        ST_CONV,
        ST_GAPC,
        ST_ENTRY,
        ST_GAPE
    } seq_st_t;

    localparam int unsigned CONV_BITS  = 16;
    localparam int unsigned WAKE_EDGES = 10;
    localparam int unsigned ENTRY_MIN  = 2;
    localparam int unsigned ENTRY_MAX  = 10;
    localparam int unsigned CYC_W      = 5;

    // Sleep-entry length, held inside the legal window of falling edges.
    function automatic logic [CYC_W-1:0] clamp_entry(input logic [3:0] req);
        logic [CYC_W-1:0] r;
        r = {1'b0, req};
        if (r < CYC_W'(ENTRY_MIN)) return CYC_W'(ENTRY_MIN);
        if (r > CYC_W'(ENTRY_MAX)) return CYC_W'(ENTRY_MAX);
        return r;
    endfunction

    // Quiet time after a wake frame, stretched to cover the wake-up time.
    function automatic logic [31:0] wake_gap(input logic [31:0] half,
                                             input logic [31:0] quiet,
                                             input logic [31:0] wake);
        logic [31:0] span;
        span = 32'(2 * WAKE_EDGES) * half;
        if (wake > span && (wake - span) > quiet) return wake - span;
        return quiet;
    endfunction

    // Cycles that one sleeping sample sequence needs, including one idle cycle.
    function automatic logic [31:0] busy_clks(input logic [31:0] half,
                                              input logic [31:0] entry,
                                              input logic [31:0] quiet,
                                              input logic [31:0] wake);
        return 32'(2 * WAKE_EDGES) * half + wake_gap(half, quiet, wake)
             + 32'(2 * CONV_BITS) * half + quiet
             + 32'd2 * entry * half + quiet + 32'd1;
    endfunction

endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen
    import sadc_pkg::*;
#(
    parameter int DIV_W = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [DIV_W-1:0] half,
    input  logic [CYC_W-1:0] ncyc,
    output logic             sclk,
    output logic             bit_tick,
    output logic             frame_last
);
    logic [DIV_W-1:0] tcnt;
    logic             hph;
    logic [CYC_W-1:0] bcnt;
    logic             half_end;

    assign half_end   = active && (tcnt == half - DIV_W'(1));
    assign bit_tick   = half_end && hph;
    assign frame_last = bit_tick && (bcnt == ncyc - CYC_W'(1));
    assign sclk       = active ? hph : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            tcnt <= '0;
            hph  <= 1'b0;
            bcnt <= '0;
        end else if (half_end) begin
            tcnt <= '0;
            if (!hph) begin
                hph <= 1'b1;
            end else begin
                hph  <= 1'b0;
                bcnt <= frame_last ? '0 : bcnt + CYC_W'(1);
            end
        end else begin
            tcnt <= tcnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
    parameter int W = 16
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         done,
    input  logic         sdo,
    output logic [W-1:0] data,
    output logic         valid
);
    logic [W-1:0] sh;
    logic [W-1:0] word_nx;

    assign word_nx = {sh[W-2:0], sdo};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= done;
            if (shift_en) sh   <= word_nx;
            if (done)     data <= word_nx;
        end
    end
endmodule

// File: rtl/sadc_pacer.sv
module sadc_pacer
    import sadc_pkg::*;
#(
    parameter int DIV_W         = 8,
    parameter int PER_W         = 16,
    parameter int QUIET_CLKS    = 4,
    parameter int WAKE_CLKS     = 200,
    parameter int PD_MIN_PERIOD = 1250
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PER_W-1:0] period,
    input  logic             sleep_en,
    input  logic [DIV_W-1:0] half,
    input  logic [CYC_W-1:0] entry,
    output logic             due,
    output logic             pd_mode,
    output logic             overrun
);
    logic [PER_W-1:0] pcnt;
    logic [31:0]      need;
    logic             fits;
    logic             pd_ok;

    assign due     = ({1'b0, pcnt} + (PER_W+1)'(1)) >= {1'b0, period};
    assign need    = busy_clks(32'(half), 32'(entry), 32'(QUIET_CLKS), 32'(WAKE_CLKS));
    assign fits    = 32'(period) >= need;
    assign pd_ok   = sleep_en && (32'(period) >= 32'(PD_MIN_PERIOD));
    assign pd_mode = pd_ok && fits;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt    <= '1;
            overrun <= 1'b0;
        end else begin
            overrun <= pd_ok && !fits;
            if (start)            pcnt <= '0;
            else if (pcnt != '1)  pcnt <= pcnt + PER_W'(1);
        end
    end
endmodule

// File: rtl/sadc_pm_ctrl.sv
module sadc_pm_ctrl
    import sadc_pkg::*;
#(
    parameter int DIV_W         = 8,
    parameter int PER_W         = 16,
    parameter int QUIET_CLKS    = 4,
    parameter int WAKE_CLKS     = 200,
    parameter int PD_MIN_PERIOD = 1250
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic [PER_W-1:0] cfg_period,
    input  logic             cfg_sleep_en,
    input  logic [3:0]       cfg_sleep_edges,
    input  logic             cfg_dummy_sleep,
    output logic             adc_cs_n,
    output logic             adc_sclk,
    input  logic             adc_sdo,
    output logic [15:0]      sample_data,
    output logic             sample_valid,
    output logic             overrun
);
    seq_st_t          st, st_nx;
    logic             asleep;
    logic [DIV_W-1:0] half;
    logic [CYC_W-1:0] entry_len, ncyc;
    logic [31:0]      wgap, gap_len, gcnt;
    logic             frame_on, gap_on, gap_done;
    logic             bit_tick, frame_last, due, pd_mode, start;

    assign half      = (cfg_half_div == '0) ? DIV_W'(1) : cfg_half_div;
    assign entry_len = clamp_entry(cfg_sleep_edges);
    assign wgap      = wake_gap(32'(half), 32'(QUIET_CLKS), 32'(WAKE_CLKS));

    assign frame_on = (st == ST_DUMMY) || (st == ST_WAKE) || (st == ST_CONV) || (st == ST_ENTRY);
    assign gap_on   = (st == ST_GAPD) || (st == ST_GAPW) || (st == ST_GAPC) || (st == ST_GAPE);
    assign gap_len  = (st == ST_GAPW) ? wgap : 32'(QUIET_CLKS);
    assign gap_done = gap_on && (gcnt == gap_len - 32'd1);
    assign start    = (st == ST_IDLE) && due;
    assign adc_cs_n = !frame_on;

    always_comb begin
        unique case (st)
            ST_DUMMY: ncyc = cfg_dummy_sleep ? entry_len : CYC_W'(CONV_BITS);
            ST_WAKE:  ncyc = CYC_W'(WAKE_EDGES);
            ST_ENTRY: ncyc = entry_len;
            default:  ncyc = CYC_W'(CONV_BITS);
        endcase
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_BOOT:  st_nx = ST_DUMMY;
            ST_DUMMY: if (frame_last) st_nx = ST_GAPD;
            ST_GAPD:  if (gap_done)   st_nx = ST_IDLE;
            ST_IDLE:  if (start)      st_nx = asleep ? ST_WAKE : ST_CONV;
            ST_WAKE:  if (frame_last) st_nx = ST_GAPW;
            ST_GAPW:  if (gap_done)   st_nx = ST_CONV;
            ST_CONV:  if (frame_last) st_nx = ST_GAPC;
            ST_GAPC:  if (gap_done)   st_nx = pd_mode ? ST_ENTRY : ST_IDLE;
            ST_ENTRY: if (frame_last) st_nx = ST_GAPE;
            ST_GAPE:  if (gap_done)   st_nx = ST_IDLE;
            default:  st_nx = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_BOOT;
            asleep <= 1'b0;
            gcnt   <= '0;
        end else begin
            st   <= st_nx;
            gcnt <= (!gap_on || gap_done) ? '0 : gcnt + 32'd1;
            if (frame_last) begin
                if (st == ST_DUMMY) asleep <= cfg_dummy_sleep;
                if (st == ST_WAKE)  asleep <= 1'b0;
                if (st == ST_ENTRY) asleep <= 1'b1;
            end
        end
    end

    sadc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk        (clk),
        .rst        (rst),
        .active     (frame_on),
        .half       (half),
        .ncyc       (ncyc),
        .sclk       (adc_sclk),
        .bit_tick   (bit_tick),
        .frame_last (frame_last)
    );

    sadc_capture #(.W(CONV_BITS)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .shift_en (bit_tick && (st == ST_CONV)),
        .done     (frame_last && (st == ST_CONV)),
        .sdo      (adc_sdo),
        .data     (sample_data),
        .valid    (sample_valid)
    );

    sadc_pacer #(
        .DIV_W         (DIV_W),
        .PER_W         (PER_W),
        .QUIET_CLKS    (QUIET_CLKS),
        .WAKE_CLKS     (WAKE_CLKS),
        .PD_MIN_PERIOD (PD_MIN_PERIOD)
    ) u_pace (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .period   (cfg_period),
        .sleep_en (cfg_sleep_en),
        .half     (half),
        .entry    (entry_len),
        .due      (due),
        .pd_mode  (pd_mode),
        .overrun  (overrun)
    );
endmodule

// File: rtl/sadc_pm_checker.sv
module sadc_pm_checker #(
    parameter int QUIET_CLKS = 4
)(
    input logic clk,
    input logic rst,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic sample_valid
);
    int unsigned hi_cnt;
    logic [4:0]  falls;
    logic        sclk_d;
    logic        fell;

    assign fell = sclk_d && !adc_sclk && !adc_cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= QUIET_CLKS;
            falls  <= '0;
            sclk_d <= 1'b1;
        end else begin
            sclk_d <= adc_sclk;
            falls  <= adc_cs_n ? 5'd0 : falls + 5'(fell);
            if (!adc_cs_n)                hi_cnt <= 0;
            else if (hi_cnt < QUIET_CLKS) hi_cnt <= hi_cnt + 1;
        end
    end

    assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> adc_sclk);

    assert_frame_span_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_n) |-> (falls >= 5'd2 && falls <= 5'd16));

    assert_quiet_gap_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> (hi_cnt >= QUIET_CLKS));

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    assert_valid_after_conv_R4: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> ($rose(adc_cs_n) && falls == 5'd16));
endmodule

bind sadc_pm_ctrl sadc_pm_checker #(.QUIET_CLKS(QUIET_CLKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .adc_cs_n     (adc_cs_n),
    .adc_sclk     (adc_sclk),
    .sample_valid (sample_valid)
);

// File: tb/tb_sadc_pm_ctrl.sv
`timescale 1ns/1ps
module tb_sadc_pm_ctrl;
    localparam int QUIET = 3;
    localparam int WAKE  = 40;
    localparam int PDMIN = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_half_div = 8'd1;
    logic [15:0] cfg_period = 16'd100;
    logic        cfg_sleep_en = 1'b0;
    logic [3:0]  cfg_sleep_edges = 4'd5;
    logic        cfg_dummy_sleep = 1'b0;
    logic        adc_cs_n, adc_sclk;
    logic        adc_sdo = 1'b0;
    logic [15:0] sample_data;
    logic        sample_valid, overrun;

    int  n_cmp = 0, n_bad = 0, el = 0, fidx = 0, falls = 0;
    logic ovr_exp = 1'b0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1;
    bit   finished = 0;

    always #2.5 clk = ~clk;

    sadc_pm_ctrl #(
        .DIV_W(8), .PER_W(16), .QUIET_CLKS(QUIET), .WAKE_CLKS(WAKE), .PD_MIN_PERIOD(PDMIN)
    ) dut (
        .clk(clk), .rst(rst), .cfg_half_div(cfg_half_div), .cfg_period(cfg_period),
        .cfg_sleep_en(cfg_sleep_en), .cfg_sleep_edges(cfg_sleep_edges),
        .cfg_dummy_sleep(cfg_dummy_sleep), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_sdo(adc_sdo), .sample_data(sample_data), .sample_valid(sample_valid),
        .overrun(overrun)
    );

    function automatic logic [15:0] word_of(input int i);
        logic [11:0] v;
        v = 12'((i * 397 + 91) ^ (i << 7));
        return {4'h0, v};
    endfunction

    // Converter model: a new word on every select fall, bits shifted out on falling clock edges.
    always @(adc_cs_n, adc_sclk) begin
        if (prev_cs && !adc_cs_n) begin
            fidx  = fidx + 1;
            falls = 0;
        end
        if (!adc_cs_n && prev_sclk && !adc_sclk) falls = falls + 1;
        prev_cs   = adc_cs_n;
        prev_sclk = adc_sclk;
        adc_sdo   = (falls >= 1 && falls <= 16) ? word_of(fidx)[16 - falls] : 1'b0;
    end

    task automatic cmp(input logic e_cs, input logic e_sclk, input logic e_val, input string tag);
        n_cmp++;
        if (adc_cs_n !== e_cs || adc_sclk !== e_sclk || sample_valid !== e_val) begin
            n_bad++;
            $display("FAIL %s t=%0t got cs_n=%b sclk=%b valid=%b expected cs_n=%b sclk=%b valid=%b",
                     tag, $time, adc_cs_n, adc_sclk, sample_valid, e_cs, e_sclk, e_val);
        end
        n_cmp++;
        if (overrun !== ovr_exp) begin
            n_bad++;
            $display("FAIL R10 t=%0t got overrun=%b expected %b", $time, overrun, ovr_exp);
        end
        if (e_val) begin
            n_cmp++;
            if (sample_data !== word_of(fidx)) begin
                n_bad++;
                $display("FAIL R4 t=%0t got data=%h expected %h", $time, sample_data, word_of(fidx));
            end
        end
    endtask

    task automatic step(input logic e_cs, input logic e_sclk, input logic e_val, input string tag);
        @(negedge clk);
        cmp(e_cs, e_sclk, e_val, tag);
        el++;
    endtask

    task automatic frame(input int n, input int h, input string tag);
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < h; j++) step(1'b0, 1'b0, 1'b0, {"R2/", tag});
            for (int j = 0; j < h; j++) step(1'b0, 1'b1, 1'b0, {"R2/", tag});
        end
    endtask

    task automatic gap(input int g, input bit vfirst, input string tag);
        for (int j = 0; j < g; j++) step(1'b1, 1'b1, (j == 0) && vfirst, tag);
    endtask

    task automatic run_case(input int div, input int period, input bit sleep_en,
                            input int edges, input bit dsleep, input int nseq);
        int h, e, span, gw, need;
        bit pdok, over, pdm, slp;
        h    = (div == 0) ? 1 : div;
        e    = (edges < 2) ? 2 : ((edges > 10) ? 10 : edges);
        span = 20 * h;
        gw   = (WAKE > span && WAKE - span > QUIET) ? WAKE - span : QUIET;
        need = 52 * h + gw + 2 * e * h + 2 * QUIET + 1;
        pdok = sleep_en && (period >= PDMIN);
        over = pdok && (period < need);
        pdm  = pdok && !over;

        cfg_half_div    = 8'(div);
        cfg_period      = 16'(period);
        cfg_sleep_en    = sleep_en;
        cfg_sleep_edges = 4'(edges);
        cfg_dummy_sleep = dsleep;
        ovr_exp         = 1'b0;
        rst             = 1'b1;
        repeat (3) begin
            @(negedge clk);
            cmp(1'b1, 1'b1, 1'b0, "R1");
        end
        rst = 1'b0;
        cmp(1'b1, 1'b1, 1'b0, "R1");
        ovr_exp = over;

        frame(dsleep ? e : 16, h, "R5");
        gap(QUIET, 0, "R3/R5");
        slp = dsleep;
        el  = period;
        for (int s = 0; s < nseq; s++) begin
            do step(1'b1, 1'b1, 1'b0, "R9"); while (el < period);
            el = 0;
            if (slp) begin
                frame(10, h, "R7");
                gap(gw, 0, "R7");
                slp = 0;
            end
            frame(16, h, pdm ? "R4" : "R8");
            gap(QUIET, 1, "R3/R4");
            if (pdm) begin
                frame(e, h, "R6");
                gap(QUIET, 0, "R3/R6");
                slp = 1;
            end
        end
    endtask

    initial begin
        run_case(2, 100, 0, 5, 0, 5);    // continuous, sleep disabled
        run_case(1, 400, 1, 5, 0, 4);    // sleep mode, wake gap stretched
        run_case(3, 500, 1, 1, 1, 4);    // sleep mode, entry clamped to 2, dummy sleeps
        run_case(1, 299, 1, 5, 1, 4);    // just below threshold: continuous after one wake
        run_case(5, 300, 1, 0, 0, 4);    // on threshold: sleep mode
        run_case(6, 345, 1, 2, 0, 4);    // one cycle short: overrun
        run_case(6, 346, 1, 2, 0, 4);    // exact fit, single idle cycle
        run_case(0, 10, 0, 12, 0, 5);    // back to back, divider 0 as 1
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired t=%0t", $time);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule